// File: doc/BRIEF.md
# Multiplexed DRAM Expansion Controller

This block drives the strobes and the shared row/column address lines of a memory expansion card. The host bus runs on a slow phase clock derived from a fast master clock. Each phase-high period is one possible memory cycle. The block samples the phase clock on the master clock. At the first master edge that sees the phase high, it takes three things: the low 16 address bits, the bank byte placed on the shared data bus at that moment, and the request line.

For an access, the low ten address bits go out first as the row. RAS then falls, and the mux switches to a column built from address bits 15..10 and bank bits 5..2. CAS follows. Bank bits 1..0 pick one of four active-high row-select lines.

Between accesses, a free-running timer marks a refresh as due. The next phase-high period without a request then carries a CAS-before-RAS refresh to one bank. The bank pointer advances after each refresh. Everything is released at the first master edge that sees the phase low again.

Top module: `xmem_dram_ctrl`

## Requirements
- R1: While reset is high and one clock after it falls with the phase low, ras_n and cas_n are 1, row_sel is 0 and ma is 0.
- R2: At the first clock edge where phase_clk is sampled 1 after being sampled 0, with req=1, ma takes cpu_addr[9:0] and row_sel becomes the one-hot code of data_bus[1:0] (bit n set for bank n). Both strobes stay 1, whatever the level of rd_wr.
- R3: On an access, ras_n goes to 0 one clock after the R2 edge.
- R4: On an access, ma becomes {bank[5:2], addr[15:10]} one clock after ras_n falls. The bank and address are the values captured at the R2 edge.
- R5: On an access, cas_n goes to 0 one clock after the column appears. It stays 0 while the phase stays high.
- R6: At the first clock edge that samples phase_clk 0 after 1, ras_n and cas_n return to 1 and row_sel to 0. They stay there while the phase is low.
- R7: A phase-high period with req=0 and no refresh due leaves both strobes at 1 and row_sel at 0 throughout.
- R8: A refresh falls due every REF_INTERVAL (default 50) clocks after reset. At a rising phase with req=0 and a refresh due, cas_n goes to 0 and row_sel selects the refresh bank at that edge. ras_n follows one clock later.
- R9: Successive refreshes target banks 0, 1, 2, 3, then 0 again.
- R10: A refresh that falls due while accesses keep occurring waits. The first rising phase with req=0 then carries it.
- R11: Changes on cpu_addr, data_bus and req after the rising phase edge do not alter the row, column or bank of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast master clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_clk | input | 1 | Host bus phase clock, sampled on clk |
| cpu_addr | input | 16 | Low 16 bits of the host address |
| data_bus | input | 8 | Shared data bus carrying the bank byte at the rising phase |
| req | input | 1 | Expansion-memory access request |
| rd_wr | input | 1 | Read/write level; does not affect strobe timing |
| ma | output | 10 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_sel | output | 4 | Per-bank row select, one-hot, active high |

## Verification
Every output is registered. Counting from the clock edge that first samples the phase high, the row and the bank select are due after that edge, ras_n one clock later, the column one clock after that, and cas_n a clock after the column. For a refresh, cas_n and the bank are due at the detecting edge and ras_n one clock later. Release is due at the edge that first samples the phase low. The bench changes inputs only on falling clock edges and samples on each falling edge that follows a counted rising edge. A timing model driven by the requirements predicts when a refresh is granted, so each sample is compared against a value fixed for that exact cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_REF_CAS,
    ST_REF_RAS
  } seq_state_t;
endpackage

// File: rtl/xmem_phase_detect.sv
module xmem_phase_detect (
  input  logic clk,
  input  logic rst,
  input  logic phase_in,
  output logic rise,
  output logic fall
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= phase_in;
  end

  assign rise = phase_in & ~phase_q;
  assign fall = ~phase_in & phase_q;
endmodule

// File: rtl/xmem_refresh_timer.sv
module xmem_refresh_timer #(
  parameter int REF_INTERVAL = 50,
  parameter int NUM_BANKS    = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         grant,
  output logic                         pending,
  output logic [$clog2(NUM_BANKS)-1:0] ptr
);
  localparam int CNT_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int SEL_W = $clog2(NUM_BANKS);

  logic [CNT_W-1:0] cnt;
  logic             hit;

  assign hit = (cnt == CNT_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt     <= hit ? '0 : cnt + 1'b1;
      pending <= hit | (pending & ~grant);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (grant) begin
      ptr <= (ptr == SEL_W'(NUM_BANKS - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xmem_sequencer.sv
module xmem_sequencer
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 8,
  parameter int MA_W      = 10,
  parameter int NUM_BANKS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rise,
  input  logic                         fall,
  input  logic                         req,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BANK_W-1:0]            bank,
  input  logic                         ref_pending,
  input  logic [$clog2(NUM_BANKS)-1:0] ref_ptr,
  output logic                         ref_grant,
  output logic [MA_W-1:0]              ma,
  output logic                         ras_n,
  output logic                         cas_n,
  output logic [NUM_BANKS-1:0]         row_sel
);
  localparam int SEL_W  = $clog2(NUM_BANKS);
  localparam int HI_W   = ADDR_W - MA_W;
  localparam int COLB_W = MA_W - HI_W;

  seq_state_t             state;
  logic [MA_W-1:0]        col_q;
  logic [MA_W-1:0]        col_d;
  logic [SEL_W-1:0]       acc_bank;
  logic [NUM_BANKS-1:0]   acc_oh;
  logic [NUM_BANKS-1:0]   ref_oh;

  assign acc_bank  = bank[SEL_W-1:0];
  assign col_d     = {bank[SEL_W +: COLB_W], addr[ADDR_W-1:MA_W]};
  assign ref_grant = rise & ~req & ref_pending;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_decode
    assign acc_oh[b] = (acc_bank == SEL_W'(b));
    assign ref_oh[b] = (ref_ptr  == SEL_W'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ma      <= '0;
      col_q   <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      row_sel <= '0;
    end else if (fall) begin
      state   <= ST_IDLE;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      row_sel <= '0;
    end else if (rise) begin
      if (req) begin
        state   <= ST_ROW;
        ma      <= addr[MA_W-1:0];
        col_q   <= col_d;
        row_sel <= acc_oh;
      end else if (ref_pending) begin
        state   <= ST_REF_CAS;
        cas_n   <= 1'b0;
        row_sel <= ref_oh;
      end
    end else begin
      unique case (state)
        ST_ROW: begin
          ras_n <= 1'b0;
          state <= ST_RAS;
        end
        ST_RAS: begin
          ma    <= col_q;
          state <= ST_COL;
        end
        ST_COL: begin
          cas_n <= 1'b0;
          state <= ST_CAS;
        end
        ST_REF_CAS: begin
          ras_n <= 1'b0;
          state <= ST_REF_RAS;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/xmem_dram_ctrl.sv
module xmem_dram_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int BANK_W       = 8,
  parameter int MA_W         = 10,
  parameter int NUM_BANKS    = 4,
  parameter int REF_INTERVAL = 50
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phase_clk,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [BANK_W-1:0]    data_bus,
  input  logic                 req,
  input  logic                 rd_wr,
  output logic [MA_W-1:0]      ma,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic [NUM_BANKS-1:0] row_sel
);
  localparam int SEL_W = $clog2(NUM_BANKS);

  logic             rise;
  logic             fall;
  logic             ref_pending;
  logic             ref_grant;
  logic [SEL_W-1:0] ref_ptr;
  logic             unused_inputs;

  assign unused_inputs = ^{rd_wr, data_bus};

  xmem_phase_detect u_phase (
    .clk      (clk),
    .rst      (rst),
    .phase_in (phase_clk),
    .rise     (rise),
    .fall     (fall)
  );

  xmem_refresh_timer #(
    .REF_INTERVAL (REF_INTERVAL),
    .NUM_BANKS    (NUM_BANKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .grant   (ref_grant),
    .pending (ref_pending),
    .ptr     (ref_ptr)
  );

  xmem_sequencer #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .MA_W      (MA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .fall        (fall),
    .req         (req),
    .addr        (cpu_addr),
    .bank        (data_bus),
    .ref_pending (ref_pending),
    .ref_ptr     (ref_ptr),
    .ref_grant   (ref_grant),
    .ma          (ma),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .row_sel     (row_sel)
  );
endmodule

// File: rtl/xmem_dram_checker.sv
module xmem_dram_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 phase_clk,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic [NUM_BANKS-1:0] row_sel
);
  // R2: at most one bank selected at any time
  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));

  // R5, R8: an asserted strobe always has exactly one bank selected
  a_r5_strobe_has_bank: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> ($countones(row_sel) == 1));

  // R3: RAS only falls after a clock that saw the phase high
  a_r3_ras_in_high: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(phase_clk));

  // R5: CAS held while the phase stays high
  a_r5_cas_hold: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && phase_clk) |=> !cas_n);

  // R6: a clock that saw the phase low leaves everything released
  a_r6_release_low: assert property (@(posedge clk) disable iff (rst)
    !$past(phase_clk) |-> (ras_n && cas_n && (row_sel == '0)));
endmodule

bind xmem_dram_ctrl xmem_dram_checker #(.NUM_BANKS(NUM_BANKS)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .phase_clk (phase_clk),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .row_sel   (row_sel)
);

// File: tb/test_xmem_dram_ctrl.sv
`timescale 1ns/1ps
module test_xmem_dram_ctrl;
  localparam int REF_INT = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  data_bus = '0;
  logic        req = 1'b0;
  logic        rd_wr = 1'b0;
  logic [9:0]  ma;
  logic        ras_n;
  logic        cas_n;
  logic [3:0]  row_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  xmem_dram_ctrl i_xmem_dram_ctrl (
    .clk(clk), .rst(rst), .phase_clk(phi), .cpu_addr(cpu_addr),
    .data_bus(data_bus), .req(req), .rd_wr(rd_wr),
    .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .row_sel(row_sel)
  );

  // Requirement-level timing model of refresh grants (R8, R9, R10)
  int m_cnt = 0;
  bit m_pend = 0;
  bit m_phi_q = 0;
  int m_ptr = 0;
  int m_last_bank = 0;
  int m_ref_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_phi_q = 0; m_ptr = 0;
    end else begin
      bit g;
      g = phi && !m_phi_q && !req && m_pend;
      if (g) begin
        m_last_bank = m_ptr;
        m_ptr = (m_ptr + 1) % 4;
        m_ref_cnt++;
      end
      if (m_cnt == REF_INT - 1) begin
        m_cnt = 0;
        m_pend = 1;
      end else begin
        m_cnt++;
        if (g) m_pend = 0;
      end
      m_phi_q = phi;
    end
  end

  task automatic check(input string rq, input bit chk_ma, input logic [9:0] e_ma,
                       input logic e_ras, input logic e_cas, input logic [3:0] e_sel);
    bit ok;
    checks++;
    ok = (ras_n === e_ras) && (cas_n === e_cas) && (row_sel === e_sel) &&
         (!chk_ma || (ma === e_ma));
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual ma=%h ras_n=%b cas_n=%b row_sel=%b expected ma=%h%s ras_n=%b cas_n=%b row_sel=%b",
               rq, ma, ras_n, cas_n, row_sel, e_ma, chk_ma ? "" : "(any)", e_ras, e_cas, e_sel);
    end
  endtask

  task automatic flag(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic run_phase(input int lo, input int hi, input bit rq, input bit wiggle,
                           output bit was_ref);
    logic [15:0] a;
    logic [7:0]  b;
    logic [9:0]  row, col;
    logic [3:0]  oh;
    int          refs_before;
    phi = 1'b0;
    for (int i = 0; i < lo; i++) begin
      @(negedge clk);
      check(i == 0 ? "R6" : "R7", 1'b0, '0, 1'b1, 1'b1, 4'b0000);
    end
    a = 16'($urandom);
    b = 8'($urandom);
    row = a[9:0];
    col = {b[5:2], a[15:10]};
    oh  = 4'b0001 << b[1:0];
    refs_before = m_ref_cnt;
    cpu_addr = a; data_bus = b; req = rq; rd_wr = 1'($urandom);
    phi = 1'b1;
    was_ref = 0;
    for (int j = 0; j < hi; j++) begin
      @(negedge clk);
      if (j == 0) was_ref = (m_ref_cnt != refs_before);
      if (rq) begin
        if (j == 0)      check("R2",     1'b1, row, 1'b1, 1'b1, oh);
        else if (j == 1) check("R3",     1'b1, row, 1'b0, 1'b1, oh);
        else if (j == 2) check("R4/R11", 1'b1, col, 1'b0, 1'b1, oh);
        else             check("R5/R11", 1'b1, col, 1'b0, 1'b0, oh);
      end else if (was_ref) begin
        check(j == 0 ? "R8/R9" : "R8", 1'b0, '0, (j == 0) ? 1'b1 : 1'b0, 1'b0,
              4'b0001 << m_last_bank);
      end else begin
        check("R7", 1'b0, '0, 1'b1, 1'b1, 4'b0000);
      end
      if (wiggle) begin
        cpu_addr = 16'($urandom); data_bus = 8'($urandom); req = 1'($urandom);
      end
    end
  endtask

  initial begin
    bit r;
    int seed;
    seed = $urandom(32'h5eed_0042);
    repeat (4) @(negedge clk);
    check("R1", 1'b1, 10'h000, 1'b1, 1'b1, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b1, 10'h000, 1'b1, 1'b1, 4'b0000);

    // Directed: short high phase (CAS never reached), long stretched phase
    run_phase(3, 3, 1'b1, 1'b0, r);
    run_phase(2, 12, 1'b1, 1'b1, r);
    run_phase(2, 5, 1'b0, 1'b0, r);

    // R10: keep accessing across a refresh deadline, then one free phase
    for (int k = 0; k < 10; k++) begin
      run_phase(2, 5, 1'b1, 1'b0, r);
      flag("R10 no refresh during access", int'(r), 0);
    end
    run_phase(2, 5, 1'b0, 1'b0, r);
    flag("R10 deferred refresh taken", int'(r), 1);

    // R9: consecutive idle-phase refreshes rotate banks
    for (int k = 0; k < 30; k++) run_phase(3, 6, 1'b0, 1'b0, r);

    // Random mix
    for (int k = 0; k < 250; k++) begin
      int lo, hi;
      lo = 2 + int'($urandom % 3);
      hi = ($urandom % 8 == 0) ? 12 : 3 + int'($urandom % 6);
      run_phase(lo, hi, 1'($urandom % 5 < 3), 1'($urandom), r);
    end
    run_phase(3, 4, 1'b0, 1'b0, r);
    phi = 1'b0;
    @(negedge clk);
    check("R6", 1'b0, '0, 1'b1, 1'b1, 4'b0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule